// File: doc/BRIEF.md
# Memory-Mapped Adder Peripheral with AXI4-Lite Slave Port

This block is a small register peripheral that software reaches over an AXI4-Lite slave port. It holds four 32-bit word slots. Two of them are writable operands. A third slot has no storage of its own: reading it returns the unsigned sum of the two operands, formed by an adder that the operand registers feed directly. The fourth slot is a plain scratch word. Software loads the two operands and then reads the sum back, with no trigger register and no wait.

The port carries one write and one read at a time. A write controller steps through `WR_IDLE`, `WR_COMMIT` and `WR_RESP`. The move `WR_IDLE -> WR_COMMIT` happens when the address and data handshakes complete together, and the captured address, data and strobes are held there. The move `WR_COMMIT -> WR_RESP` applies the strobed write to the register file. The move `WR_RESP -> WR_IDLE` happens when the master takes the response. A read controller steps through `RD_IDLE`, `RD_LOAD` and `RD_DATA`. The move `RD_IDLE -> RD_LOAD` happens when the read address is accepted and captured. The move `RD_LOAD -> RD_DATA` registers the word selected for the captured address. The move `RD_DATA -> RD_IDLE` happens when the master takes the data.

Top module: `axil_adder`

## Requirements
- R1: An active-low synchronous reset clears every stored slot and returns both controllers to idle. After reset, `bvalid` and `rvalid` are 0, and reads of offsets 0x0, 0x4, 0x8 and 0xC all return 0.
- R2: A write to offset 0x0 stores operand A, and a write to offset 0x4 stores operand B. Reading the same offset returns the stored word.
- R3: A read of offset 0x8 returns (A + B) mod 2^32, formed from the current operands. For example, A=0xdead and B=0xbeef give 0x19d9c, and A=0xffffffff with B=2 gives 1.
- R4: A write to offset 0x8 has no effect. Operands A and B and the sum read back unchanged.
- R5: Offset 0xC is a read/write scratch word that does not affect the sum.
- R6: Write data bits [8i+7:8i] reach the addressed slot only when `wstrb[i]` is 1. Lanes whose strobe is 0 keep their old value.
- R7: Byte address bits [3:2] select the slot, and bits [1:0] are ignored on both writes and reads.
- R8: A write is taken only when `awvalid` and `wvalid` are both high. With only one of them high, `awready` and `wready` stay 0.
- R9: Once raised, `bvalid` stays high until `bready` is sampled high, and `bresp` is 2'b00 (OKAY).
- R10: Once raised, `rvalid` stays high with `rdata` unchanged until `rready` is sampled high, and `rresp` is 2'b00 (OKAY).
- R11: While a write response is pending, `awready` and `wready` are 0. While read data is pending, `arready` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Active-low synchronous reset |
| awaddr | input | ADDR_W | Write byte address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Write byte strobes |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response code |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | ADDR_W | Read byte address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response code |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |

## Verification
The bench builds the block with its default parameters: 32-bit data, four slots and therefore a 4-bit byte address. At that size it can write to every one of the 16 byte addresses under every one of the 16 strobe masks, and after each write it reads all four slots through varied low address bits. This covers each slot, each lane pattern and the ignored address bits, with the sum and the stored words predicted by arithmetic in the bench. Directed cases then cover the worked sum, carry-out wrap, writes aimed at the sum slot, handshakes with only one valid, and back-pressure on both response channels.

// File: rtl/axil_adder_pkg.sv
package axil_adder_pkg;

    localparam int SUM_SLOT = 2;
    localparam int OPA_SLOT = 0;
    localparam int OPB_SLOT = 1;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    typedef enum logic [1:0] {
        WR_IDLE   = 2'd0,
        WR_COMMIT = 2'd1,
        WR_RESP   = 2'd2
    } wr_state_t;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_LOAD = 2'd1,
        RD_DATA = 2'd2
    } rd_state_t;

endpackage

// File: rtl/axil_wr_ctrl.sv
module axil_wr_ctrl
    import axil_adder_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int SEL_W  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     awaddr,
    input  logic                  awvalid,
    output logic                  awready,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [DATA_W/8-1:0]   wstrb,
    input  logic                  wvalid,
    output logic                  wready,
    output logic [1:0]            bresp,
    output logic                  bvalid,
    input  logic                  bready,
    output logic                  wr_en,
    output logic [SEL_W-1:0]      wr_sel,
    output logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W/8-1:0]   wr_strb
);

    localparam int LANE_BITS = ADDR_W - SEL_W;

    wr_state_t state_q, state_d;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   data_q;
    logic [DATA_W/8-1:0] strb_q;
    logic                take;

    assign take = (state_q == WR_IDLE) && awvalid && wvalid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE:   if (take) state_d = WR_COMMIT;
            WR_COMMIT: state_d = WR_RESP;
            WR_RESP:   if (bready) state_d = WR_IDLE;
            default:   state_d = WR_IDLE;
        endcase
    end

    always_comb begin
        awready = 1'b0;
        wready  = 1'b0;
        bvalid  = 1'b0;
        wr_en   = 1'b0;
        unique case (state_q)
            WR_IDLE: begin
                awready = awvalid && wvalid;
                wready  = awvalid && wvalid;
            end
            WR_COMMIT: wr_en  = 1'b1;
            WR_RESP:   bvalid = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            strb_q <= '0;
        end else if (take) begin
            addr_q <= awaddr;
            data_q <= wdata;
            strb_q <= wstrb;
        end
    end

    assign bresp   = RESP_OKAY;
    assign wr_sel  = addr_q[ADDR_W-1:LANE_BITS];
    assign wr_data = data_q;
    assign wr_strb = strb_q;

    a_r9_bvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);

    a_r9_okay_resp: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> (bresp == 2'b00));

    a_r8_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid != wvalid) |-> (!awready && !wready));

    a_r11_aw_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> (!awready && !wready));

    a_r11_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

endmodule

// File: rtl/axil_rd_ctrl.sv
module axil_rd_ctrl
    import axil_adder_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    output logic [SEL_W-1:0]  rd_sel,
    input  logic [DATA_W-1:0] rd_word
);

    localparam int LANE_BITS = ADDR_W - SEL_W;

    rd_state_t state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (arvalid) state_d = RD_LOAD;
            RD_LOAD: state_d = RD_DATA;
            RD_DATA: if (rready) state_d = RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_comb begin
        arready = 1'b0;
        rvalid  = 1'b0;
        unique case (state_q)
            RD_IDLE: arready = 1'b1;
            RD_LOAD: ;
            RD_DATA: rvalid = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (state_q == RD_IDLE && arvalid) addr_q <= araddr;
            if (state_q == RD_LOAD) data_q <= rd_word;
        end
    end

    assign rd_sel = addr_q[ADDR_W-1:LANE_BITS];
    assign rdata  = data_q;
    assign rresp  = RESP_OKAY;

    a_r10_rvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));

    a_r10_okay_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (rresp == 2'b00));

    a_r11_ar_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !arready);

endmodule

// File: rtl/axil_add_regs.sv
module axil_add_regs
    import axil_adder_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int N_SLOTS = 4,
    parameter int SEL_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W/8-1:0] wr_strb,
    input  logic [SEL_W-1:0]    rd_sel,
    output logic [DATA_W-1:0]   rd_word
);

    localparam int LANES = DATA_W / 8;
    localparam logic [SEL_W-1:0] SUM_IDX = SEL_W'(SUM_SLOT);

    logic [N_SLOTS-1:0][DATA_W-1:0] slot_w;
    logic [DATA_W-1:0]              sum_w;

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        if (s == SUM_SLOT) begin : g_computed
            assign slot_w[s] = '0;
        end else begin : g_stored
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en && (wr_sel == SEL_W'(s))) begin
                    for (int b = 0; b < LANES; b++) begin
                        if (wr_strb[b]) q[8*b +: 8] <= wr_data[8*b +: 8];
                    end
                end
            end
            assign slot_w[s] = q;
        end
    end

    assign sum_w = slot_w[OPA_SLOT] + slot_w[OPB_SLOT];

    always_comb begin
        if (rd_sel == SUM_IDX) begin
            rd_word = sum_w;
        end else begin
            rd_word = slot_w[rd_sel];
        end
    end

    a_r4_sum_slot_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SUM_IDX) |=> $stable(slot_w));

    a_r6_no_lanes_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_strb == '0) |=> $stable(slot_w));

    a_r5_scratch_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_W'(N_SLOTS-1)) |=> $stable(sum_w));

    a_r2_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(slot_w));

endmodule

// File: rtl/axil_adder.sv
module axil_adder
    import axil_adder_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int N_SLOTS = 4,
    parameter int ADDR_W  = $clog2(N_SLOTS) + $clog2(DATA_W / 8)
) (
    input  logic                aclk,
    input  logic                aresetn,
    input  logic [ADDR_W-1:0]   awaddr,
    input  logic                awvalid,
    output logic                awready,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    input  logic                wvalid,
    output logic                wready,
    output logic [1:0]          bresp,
    output logic                bvalid,
    input  logic                bready,
    input  logic [ADDR_W-1:0]   araddr,
    input  logic                arvalid,
    output logic                arready,
    output logic [DATA_W-1:0]   rdata,
    output logic [1:0]          rresp,
    output logic                rvalid,
    input  logic                rready
);

    localparam int SEL_W = $clog2(N_SLOTS);

    logic                wr_en;
    logic [SEL_W-1:0]    wr_sel;
    logic [DATA_W-1:0]   wr_data;
    logic [DATA_W/8-1:0] wr_strb;
    logic [SEL_W-1:0]    rd_sel;
    logic [DATA_W-1:0]   rd_word;

    axil_wr_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_wr (
        .clk(aclk), .rst_n(aresetn),
        .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .wr_strb(wr_strb)
    );

    axil_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_rd (
        .clk(aclk), .rst_n(aresetn),
        .araddr(araddr), .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
        .rd_sel(rd_sel), .rd_word(rd_word)
    );

    axil_add_regs #(.DATA_W(DATA_W), .N_SLOTS(N_SLOTS), .SEL_W(SEL_W)) u_regs (
        .clk(aclk), .rst_n(aresetn),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .wr_strb(wr_strb),
        .rd_sel(rd_sel), .rd_word(rd_word)
    );

    a_r1_quiet_after_reset: assert property (@(posedge aclk)
        !aresetn |=> (!bvalid && !rvalid));

endmodule

// File: tb/sim_axil_adder.sv
`timescale 1ns/1ps
module sim_axil_adder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  awaddr = '0;
    logic        awvalid = 1'b0;
    logic        awready;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        wvalid = 1'b0;
    logic        wready;
    logic [1:0]  bresp;
    logic        bvalid;
    logic        bready = 1'b0;
    logic [3:0]  araddr = '0;
    logic        arvalid = 1'b0;
    logic        arready;
    logic [31:0] rdata;
    logic [1:0]  rresp;
    logic        rvalid;
    logic        rready = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] model [4];

    always #5 clk = ~clk;

    axil_adder u0 (
        .aclk(clk), .aresetn(rst_n),
        .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .araddr(araddr), .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_word(input int idx);
        if (idx == 2) return model[0] + model[1];
        return model[idx];
    endfunction

    task automatic model_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s);
        int idx = int'(a[3:2]);
        if (idx == 2) return;
        for (int b = 0; b < 4; b++) if (s[b]) model[idx][8*b +: 8] = d[8*b +: 8];
    endtask

    task automatic axi_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s,
                             input bit stagger, input bit probe);
        @(negedge clk);
        awaddr = a; awvalid = 1'b1;
        wdata = d; wstrb = s;
        if (stagger) begin
            wvalid = 1'b0;
            #1;
            chk(!awready && !wready, "R8 ready with address only", {30'd0, awready, wready}, 32'd0);
            @(negedge clk);
            awvalid = 1'b0; wvalid = 1'b1;
            #1;
            chk(!awready && !wready, "R8 ready with data only", {30'd0, awready, wready}, 32'd0);
            @(negedge clk);
            awvalid = 1'b1;
        end else begin
            wvalid = 1'b1;
        end
        #1;
        while (!(awready && wready)) begin
            @(negedge clk); #1;
        end
        @(posedge clk);
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
        while (!bvalid) @(negedge clk);
        model_write(a, d, s);
        if (probe) begin
            awvalid = 1'b1; wvalid = 1'b1;
            #1;
            chk(!awready && !wready, "R11 write accepted while response pending", {30'd0, awready, wready}, 32'd0);
            awvalid = 1'b0; wvalid = 1'b0;
        end
        @(negedge clk);
        chk(bvalid === 1'b1, "R9 bvalid dropped without bready", {31'd0, bvalid}, 32'd1);
        chk(bresp === 2'b00, "R9 bresp not OKAY", {30'd0, bresp}, 32'd0);
        bready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bready = 1'b0;
        chk(bvalid === 1'b0, "R9 bvalid after accept", {31'd0, bvalid}, 32'd0);
    endtask

    task automatic axi_read(input logic [3:0] a, input bit probe, output logic [31:0] d);
        logic [31:0] first;
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        #1;
        while (!arready) begin
            @(negedge clk); #1;
        end
        @(posedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        while (!rvalid) @(negedge clk);
        first = rdata;
        if (probe) begin
            arvalid = 1'b1;
            #1;
            chk(!arready, "R11 read accepted while data pending", {31'd0, arready}, 32'd0);
            arvalid = 1'b0;
        end
        @(negedge clk);
        chk(rvalid === 1'b1 && rdata === first, "R10 rdata not held", rdata, first);
        chk(rresp === 2'b00, "R10 rresp not OKAY", {30'd0, rresp}, 32'd0);
        rready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rready = 1'b0;
        d = first;
    endtask

    task automatic read_chk(input logic [3:0] a, input string req);
        logic [31:0] got;
        logic [31:0] exp;
        axi_read(a, 1'b0, got);
        exp = expect_word(int'(a[3:2]));
        chk(got === exp, req, got, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        for (int i = 0; i < 4; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(bvalid === 1'b0 && rvalid === 1'b0, "R1 valids after reset", {30'd0, bvalid, rvalid}, 32'd0);
        for (int i = 0; i < 4; i++) read_chk(4'(i * 4), "R1 slot after reset");

        // R3 worked sum
        axi_write(4'h0, 32'h0000dead, 4'hf, 1'b0, 1'b0);
        axi_write(4'h4, 32'h0000beef, 4'hf, 1'b0, 1'b1);
        axi_read(4'h8, 1'b1, got);
        chk(got === 32'h00019d9c, "R3 dead+beef", got, 32'h00019d9c);
        read_chk(4'h0, "R2 operand A readback");
        read_chk(4'h4, "R2 operand B readback");

        // R3 wrap
        axi_write(4'h0, 32'hffffffff, 4'hf, 1'b0, 1'b0);
        axi_write(4'h4, 32'h00000002, 4'hf, 1'b1, 1'b0);
        axi_read(4'h8, 1'b0, got);
        chk(got === 32'h00000001, "R3 carry wrap", got, 32'h1);

        // R4 write to sum slot ignored
        axi_write(4'h8, 32'h12345678, 4'hf, 1'b0, 1'b0);
        read_chk(4'h8, "R4 sum after write to 0x8");
        read_chk(4'h0, "R4 operand A after write to 0x8");
        read_chk(4'h4, "R4 operand B after write to 0x8");

        // R5 scratch
        axi_write(4'hc, 32'hcafef00d, 4'hf, 1'b0, 1'b0);
        read_chk(4'hc, "R5 scratch readback");
        read_chk(4'h8, "R5 sum unaffected by scratch");

        // R6 R7 sweep over every byte address and strobe mask
        for (int a = 0; a < 16; a++) begin
            for (int s = 0; s < 16; s++) begin
                logic [31:0] d = 32'h9e3779b9 * 32'(a * 16 + s + 1);
                axi_write(4'(a), d, 4'(s), s[0] ^ a[0], 1'b0);
                for (int k = 0; k < 4; k++) begin
                    logic [3:0] ra = {2'(k), 2'(a + s)};
                    read_chk(ra, (k == 2) ? "R3 R6 R7 sum in sweep" :
                                 (k == 3) ? "R5 R6 R7 scratch in sweep" :
                                            "R2 R6 R7 operand in sweep");
                end
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule